// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two signed two's complement operands over several clock cycles and returns the full double-width signed product. A request is issued by raising `start` for one cycle while the block is idle. At that edge the operands are captured: the absolute value of the first operand is placed in a multiplicand register. The absolute value of the second operand is placed in the low half of a double-width accumulator whose upper half is cleared.

Each iteration looks at accumulator bit 0. If that bit is 1, the multiplicand is added to the upper half, and the adder's carry-out is kept. The accumulator and the carry then shift right together by one place. After one iteration per operand bit, a single correction cycle negates the accumulator when the operand signs differ. `done` then pulses for one cycle and the result stays on `product` until the next accepted request.

The design is parameterised by the operand width `W`, which defaults to 32.

Top module: `seq_mult`

## Requirements
- R1: While reset is active, and right after it is released, `busy` and `done` are 0 and `product` is all zeros.
- R2: When `start` is sampled high while `busy` is 0, `busy` is 1 from the next cycle and stays 1 for exactly W+1 cycles: W add/shift iterations plus one sign-correction cycle.
- R3: `done` is high for exactly one cycle, and that cycle is the first cycle in which `busy` is 0 again. With `start` sampled at clock edge k, `done` is 1 between edges k+W+1 and k+W+2.
- R4: For operands whose top bit is 0, `product` equals their unsigned product. For example, 3 times 11 gives 33.
- R5: For any operand pair, including the most negative value, `product` read as a 2W-bit two's complement number equals the signed product. The result is negated exactly when the top bits of the two operands differ.
- R6: `start` and operand changes while `busy` is 1 have no effect: the result and the timing of `done` follow the operands captured at the accepted start.
- R7: While `busy` is 0 and `start` is 0, `product` holds its value, whatever the operand inputs do.
- R8: A `start` sampled in the cycle where `done` is high is accepted and begins a new multiplication.
- R9: A zero operand, with either sign on the other operand, gives an all-zero product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a multiplication; accepted only when idle |
| op_a | input | W | Signed operand, becomes the multiplicand |
| op_b | input | W | Signed operand, loaded into the low accumulator half |
| busy | output | 1 | High while iterating or correcting the sign |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2W | Signed double-width result |

## Verification
Two functions can fall in the same cycle. The first is the completion pulse together with the acceptance of a new request. The bench provokes this by raising `start` in the very cycle it sees `done`. It then judges that `busy` rises on the next edge, that `done` does not repeat, and that the second product arrives W+1 cycles later with its own value. The second is a request that arrives while iterations are still running. The bench pulses `start` with fresh operands mid-run and checks that the original product and the original completion cycle are kept.

// File: rtl/mul_pkg.sv
package mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } mul_state_e;
endpackage

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import mul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic fix,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  mul_state_e      st_q;
  logic [CW-1:0]   iter_q;
  logic            done_q;
  logic            last_step;

  assign busy      = (st_q != ST_IDLE);
  assign load      = start && (st_q == ST_IDLE);
  assign step      = (st_q == ST_RUN);
  assign fix       = (st_q == ST_FIX);
  assign last_step = step && (iter_q == CW'(W - 1));
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      iter_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= fix;
      case (st_q)
        ST_IDLE: begin
          iter_q <= '0;
          if (start) st_q <= ST_RUN;
        end
        ST_RUN: begin
          iter_q <= iter_q + 1'b1;
          if (last_step) st_q <= ST_FIX;
        end
        ST_FIX:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mul_dp.sv
module mul_dp #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           fix,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic [2*W-1:0] prod_q,
  output logic [W-1:0]   mcand_q,
  output logic           add_now
);
  localparam int W2 = 2 * W;

  logic       neg_q;
  logic [W:0] hi_sum;

  function automatic logic [W-1:0] abs_val(input logic [W-1:0] x);
    return x[W-1] ? (~x + 1'b1) : x;
  endfunction

  function automatic logic [W2-1:0] negate2(input logic [W2-1:0] x);
    return ~x + 1'b1;
  endfunction

  function automatic logic [W:0] upper_add(input logic [W-1:0] hi,
                                           input logic [W-1:0] m,
                                           input logic         en);
    return {1'b0, hi} + (en ? {1'b0, m} : {(W + 1){1'b0}});
  endfunction

  assign add_now = step && prod_q[0];
  assign hi_sum  = upper_add(prod_q[W2-1:W], mcand_q, prod_q[0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q  <= '0;
      mcand_q <= '0;
      neg_q   <= 1'b0;
    end else if (load) begin
      mcand_q <= abs_val(op_a);
      prod_q  <= {{W{1'b0}}, abs_val(op_b)};
      neg_q   <= op_a[W-1] ^ op_b[W-1];
    end else if (step) begin
      prod_q  <= {hi_sum, prod_q[W-1:1]};
    end else if (fix) begin
      prod_q  <= neg_q ? negate2(prod_q) : prod_q;
    end
  end
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  logic           load;
  logic           step;
  logic           fix;
  logic           add_now;
  logic [W-1:0]   mcand_q;
  logic [2*W-1:0] prod_q;

  mul_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .fix   (fix),
    .busy  (busy),
    .done  (done)
  );

  mul_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .step    (step),
    .fix     (fix),
    .op_a    (op_a),
    .op_b    (op_b),
    .prod_q  (prod_q),
    .mcand_q (mcand_q),
    .add_now (add_now)
  );

  assign product = prod_q;
endmodule

// File: rtl/mul_chk.sv
module mul_chk #(
  parameter int W = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic           add_now,
  input logic [W-1:0]   mcand_q,
  input logic [2*W-1:0] product
);
  localparam int BW = $clog2(W + 2) + 1;

  logic [BW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_cnt <= '0;
    else if (start && !busy)   busy_cnt <= '0;
    else if (busy)             busy_cnt <= busy_cnt + 1'b1;
  end

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (busy_cnt == BW'(W + 1)));

  // R2
  add_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    add_now |-> busy);

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R6
  mcand_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mcand_q));

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(product));
endmodule

bind seq_mult mul_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .busy    (busy),
  .done    (done),
  .add_now (add_now),
  .mcand_q (mcand_q),
  .product (product)
);

// File: tb/sim_seq_mult.sv
`timescale 1ns/1ps
module sim_seq_mult;
  localparam int W  = 6;
  localparam int W2 = 2 * W;
  localparam int LO = -(1 << (W - 1));
  localparam int HI = (1 << (W - 1)) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          busy;
  logic          done;
  logic [W2-1:0] product;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  seq_mult #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W2-1:0] ref_prod(input int a, input int b);
    longint p;
    p = longint'(a) * longint'(b);
    return p[W2-1:0];
  endfunction

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic issue(input int a, input int b);
    op_a  = a[W-1:0];
    op_b  = b[W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_one(input int a, input int b, input string req);
    int cyc;
    issue(a, b);
    check(busy == 1'b1, "R2", busy, 1);
    wait_done(cyc);
    check(cyc == W + 1, "R3", cyc, W + 1);
    check(busy == 1'b0, "R3", busy, 0);
    check(product == ref_prod(a, b), req, $signed(product), $signed(ref_prod(a, b)));
    @(negedge clk);
    check(done == 1'b0, "R3", done, 0);
  endtask

  initial begin
    #600000;
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int cyc;
    logic [W2-1:0] held;
    repeat (3) @(negedge clk);
    // R1: reset state while reset is active
    check(busy == 0 && done == 0, "R1", {busy, done}, 0);
    check(product == '0, "R1", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && product == '0, "R1", product, 0);

    // R4: 3 times 11
    run_one(3, 11, "R4");
    // R9: zero operands
    run_one(0, LO, "R9");
    run_one(-7, 0, "R9");

    // R4/R5: exhaustive sweep
    for (int a = LO; a <= HI; a++) begin
      for (int b = LO; b <= HI; b++) begin
        run_one(a, b, (a >= 0 && b >= 0) ? "R4" : "R5");
      end
    end

    // R6: start and operand change while busy are ignored
    issue(-13, 9);
    repeat (2) @(negedge clk);
    op_a = 6'd5; op_b = 6'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_a = 6'd31; op_b = 6'd31;
    cyc = 3;
    while (!done) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == W + 1, "R6", cyc, W + 1);
    check(product == ref_prod(-13, 9), "R6", $signed(product), $signed(ref_prod(-13, 9)));

    // R7: result holds while idle with moving inputs
    held = product;
    for (int i = 0; i < 6; i++) begin
      op_a = 6'(i * 11); op_b = 6'(i * 5 + 3);
      @(negedge clk);
      check(product == held && busy == 0, "R7", product, held);
    end

    // R8: start in the done cycle is accepted
    issue(LO, LO);
    wait_done(cyc);
    check(product == ref_prod(LO, LO), "R5", $signed(product), $signed(ref_prod(LO, LO)));
    issue(-21, 17);
    check(busy == 1'b1 && done == 1'b0, "R8", {busy, done}, 2);
    wait_done(cyc);
    check(cyc == W + 1, "R8", cyc, W + 1);
    check(product == ref_prod(-21, 17), "R8", $signed(product), $signed(ref_prod(-21, 17)));
    @(negedge clk);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule